// File: doc/BRIEF.md
# Misaligned Access Bus Splitter

The splitter sits between a load/store unit and a 32-bit external data bus. It takes one operand request at a time. A request carries an address, a size (byte, word or longword), a direction, write data and a flag that marks an instruction fetch. Byte operands are aligned at any address, words at even addresses and longwords at multiples of four. An aligned request goes to the bus as one cycle. A misaligned data request is never refused. It is turned into a chain of naturally aligned byte and word cycles, each with its own address, size code and byte-lane steering. Each cycle waits for the slave's acknowledge before the next one is presented.

On reads, the bytes returned by each piece are gathered in operand order and presented right-justified with one completion pulse. On writes, the operand bytes are steered onto the big-endian lanes that each piece addresses. An instruction fetch at an odd address never reaches the bus. It produces an address-error pulse instead.

Top module: `ldst_split`

## Requirements
- R1: An aligned request produces exactly one bus cycle at the request address. The size code is 01 for byte, 10 for word and 00 for longword. Every bus cycle is naturally aligned for the size it carries.
- R2: A word at an odd address becomes two byte cycles, at the address and at the address plus one.
- R3: A longword at offset 1 becomes a byte cycle at offset 1, then a word cycle at offset 2, then a byte cycle at offset 0 of the following longword.
- R4: A longword at offset 3 becomes a byte cycle at offset 3, then a word cycle at offset 0 of the following longword, then a byte cycle at offset 2 of that longword.
- R5: A longword at offset 2 becomes two word cycles, at the address and at the address plus two.
- R6: Lanes are big-endian: offset 0 is bus_wdata[31:24] and offset 3 is bits [7:0]. The operand's most significant byte goes to the lowest address. Lanes that the current cycle does not address are driven zero, and a read drives all write lanes zero.
- R7: done pulses for exactly one cycle, one cycle after the final acknowledge. At that point rdata holds the read operand right-justified and zero-extended, or zero after a write.
- R8: bus_valid stays high, and address, size and write lanes stay stable, until bus_ack is seen. The next piece appears in the cycle after the acknowledge.
- R9: An instruction fetch with address bit 0 set starts no bus cycle and gives no done. It raises addr_err for one cycle, one cycle after acceptance.
- R10: req_ready is high only while no split is in progress. It drops in the cycle after acceptance and rises together with done.
- R11: During reset, and for two clocks after rst_n rises, req_ready, bus_valid, done and addr_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operand request present |
| req_ready | output | 1 | Splitter idle, request taken when valid |
| req_addr | input | 32 | Operand byte address |
| req_size | input | 2 | Operand size: 01 byte, 10 word, 00 longword |
| req_write | input | 1 | 1 for store, 0 for load |
| req_ifetch | input | 1 | Request is an instruction fetch |
| req_wdata | input | 32 | Store operand, right-justified |
| done | output | 1 | One-cycle completion pulse |
| addr_err | output | 1 | One-cycle address-error pulse |
| rdata | output | 32 | Load operand, right-justified, valid with done |
| bus_valid | output | 1 | Bus cycle presented |
| bus_addr | output | 32 | Byte address of the current piece |
| bus_size | output | 2 | Size code of the current piece |
| bus_write | output | 1 | Direction of the current piece |
| bus_wdata | output | 32 | Write data steered to lanes |
| bus_ack | input | 1 | Slave acknowledge of the current piece |
| bus_rdata | input | 32 | Read data from the slave |

## Verification
Completion of one operand and acceptance of the next can fall in the same cycle. The final acknowledge pulses done and raises req_ready together, and a request that is already waiting is taken on that same edge. The bench keeps req_valid high with a queue of back-to-back requests, so this overlap happens on nearly every operand. Its reference model checks, on every clock, that done and rdata belong to the old operand while the first piece of the new one appears one cycle later. Random acknowledge gaps shift where the overlap lands relative to each split.

// File: rtl/lsplit_pkg.sv
package lsplit_pkg;

  // bus size codes; the encoding is visible on the bus
  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_WORD = 2'b10
  } bus_size_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } split_st_e;

endpackage

// File: rtl/lsplit_plan.sv
// Picks the largest naturally aligned piece that starts at the cursor
// offset and does not exceed the bytes still owed.
module lsplit_plan
  import lsplit_pkg::*;
#(
  parameter int LW = 2,
  parameter int CW = 3
) (
  input  logic [LW-1:0] lo,
  input  logic [CW-1:0] remain,
  output logic [1:0]    pc_size,
  output logic [CW-1:0] pc_bytes
);

  always_comb begin
    if (lo[1:0] == 2'b00 && remain >= CW'(4)) begin
      pc_size  = SZ_LONG;
      pc_bytes = CW'(4);
    end else if (!lo[0] && remain >= CW'(2)) begin
      pc_size  = SZ_WORD;
      pc_bytes = CW'(2);
    end else begin
      pc_size  = SZ_BYTE;
      pc_bytes = CW'(1);
    end
  end

endmodule

// File: rtl/lsplit_lanes.sv
// Big-endian lane steering: write bytes onto the addressed lanes and
// extract the addressed read lanes right-justified.
module lsplit_lanes #(
  parameter int DW    = 32,
  parameter int LANES = DW / 8,
  parameter int LW    = 2,
  parameter int CW    = 3
) (
  input  logic [LW-1:0] lo,
  input  logic [CW-1:0] pc_bytes,
  input  logic [DW-1:0] wsh,
  input  logic [DW-1:0] rbus,
  output logic [DW-1:0] wlanes,
  output logic [DW-1:0] rpart
);

  logic [LANES-1:0] lane_on;
  logic [DW-1:0]    mask;
  logic [7:0]       sh_w;
  logic [7:0]       sh_r;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_on[g] = (g >= int'(lo)) && (g < int'(lo) + int'(pc_bytes));
    assign mask[DW-1-8*g -: 8] = {8{lane_on[g]}};
  end

  assign sh_w   = 8'({lo, 3'b000});
  assign sh_r   = 8'(8 * (LANES - int'(lo) - int'(pc_bytes)));
  assign wlanes = (wsh >> sh_w) & mask;
  assign rpart  = (rbus & mask) >> sh_r;

endmodule

// File: rtl/lsplit_ctrl.sv
// Sequencer: accepts a request, walks the cursor through the pieces,
// shifts write data out and read data in, and raises the pulses.
module lsplit_ctrl
  import lsplit_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int LANES = DW / 8,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          req_write,
  input  logic          req_ifetch,
  input  logic [DW-1:0] req_wdata,
  input  logic          bus_ack,
  input  logic [CW-1:0] pc_bytes,
  input  logic [DW-1:0] rpart,
  output logic          idle,
  output logic          run,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] remain,
  output logic [DW-1:0] wsh,
  output logic          wr,
  output logic          done,
  output logic          addr_err,
  output logic [DW-1:0] rdata
);

  split_st_e     st_q, st_n;
  logic [AW-1:0] addr_q, addr_n;
  logic [CW-1:0] rem_q, rem_n;
  logic [DW-1:0] wsh_q, wsh_n;
  logic [DW-1:0] rh_q, rh_n;
  logic          wr_q, wr_n;
  logic          done_q, done_n;
  logic          err_q, err_n;
  logic          ld_en;
  logic [CW-1:0] op_bytes;
  logic [7:0]    wsh_amt;
  logic [7:0]    step_amt;

  always_comb begin
    case (req_size)
      SZ_BYTE: op_bytes = CW'(1);
      SZ_WORD: op_bytes = CW'(2);
      default: op_bytes = CW'(4);
    endcase
  end

  assign wsh_amt  = 8'(8 * (LANES - int'(op_bytes)));
  assign step_amt = 8'(8 * int'(pc_bytes));

  // next state
  always_comb begin
    st_n   = st_q;
    addr_n = addr_q;
    rem_n  = rem_q;
    wsh_n  = wsh_q;
    rh_n   = rh_q;
    wr_n   = wr_q;
    done_n = 1'b0;
    err_n  = 1'b0;
    ld_en  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          ld_en = 1'b1;
          if (req_ifetch && req_addr[0]) begin
            err_n = 1'b1;
          end else begin
            st_n   = ST_RUN;
            addr_n = req_addr;
            rem_n  = op_bytes;
            wsh_n  = req_write ? (req_wdata << wsh_amt) : '0;
            rh_n   = '0;
            wr_n   = req_write;
          end
        end
      end
      ST_RUN: begin
        if (bus_ack) begin
          ld_en  = 1'b1;
          addr_n = addr_q + AW'(pc_bytes);
          rem_n  = rem_q - pc_bytes;
          wsh_n  = wsh_q << step_amt;
          if (!wr_q) rh_n = (rh_q << step_amt) | rpart;
          if (rem_q == pc_bytes) begin
            st_n   = ST_IDLE;
            done_n = 1'b1;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      rem_q  <= '0;
      wsh_q  <= '0;
      rh_q   <= '0;
      wr_q   <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= done_n;
      err_q  <= err_n;
      if (ld_en) begin
        st_q   <= st_n;
        addr_q <= addr_n;
        rem_q  <= rem_n;
        wsh_q  <= wsh_n;
        rh_q   <= rh_n;
        wr_q   <= wr_n;
      end
    end
  end

  assign idle     = (st_q == ST_IDLE);
  assign run      = (st_q == ST_RUN);
  assign cur_addr = addr_q;
  assign remain   = rem_q;
  assign wsh      = wsh_q;
  assign wr       = wr_q;
  assign done     = done_q;
  assign addr_err = err_q;
  assign rdata    = rh_q;

endmodule

// File: rtl/ldst_split.sv
module ldst_split
  import lsplit_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          req_write,
  input  logic          req_ifetch,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic          addr_err,
  output logic [DW-1:0] rdata,
  output logic          bus_valid,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic          bus_write,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata
);

  localparam int LANES = DW / 8;
  localparam int LW    = $clog2(LANES);
  localparam int CW    = $clog2(LANES + 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_m_n, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_n <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      rst_m_n <= 1'b1;
      rst_q_n <= rst_m_n;
    end
  end

  logic          idle, run, wr;
  logic [AW-1:0] cur_addr;
  logic [CW-1:0] remain, pc_bytes;
  logic [1:0]    pc_size;
  logic [DW-1:0] wsh, wlanes, rpart;

  lsplit_plan #(.LW(LW), .CW(CW)) u_plan (
    .lo       (cur_addr[LW-1:0]),
    .remain   (remain),
    .pc_size  (pc_size),
    .pc_bytes (pc_bytes)
  );

  lsplit_lanes #(.DW(DW), .LANES(LANES), .LW(LW), .CW(CW)) u_lanes (
    .lo       (cur_addr[LW-1:0]),
    .pc_bytes (pc_bytes),
    .wsh      (wsh),
    .rbus     (bus_rdata),
    .wlanes   (wlanes),
    .rpart    (rpart)
  );

  lsplit_ctrl #(.AW(AW), .DW(DW), .LANES(LANES), .CW(CW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .req_write  (req_write),
    .req_ifetch (req_ifetch),
    .req_wdata  (req_wdata),
    .bus_ack    (bus_ack),
    .pc_bytes   (pc_bytes),
    .rpart      (rpart),
    .idle       (idle),
    .run        (run),
    .cur_addr   (cur_addr),
    .remain     (remain),
    .wsh        (wsh),
    .wr         (wr),
    .done       (done),
    .addr_err   (addr_err),
    .rdata      (rdata)
  );

  assign req_ready = idle & rst_q_n;
  assign bus_valid = run;
  assign bus_addr  = cur_addr;
  assign bus_size  = pc_size;
  assign bus_write = wr;
  assign bus_wdata = wlanes;

endmodule

// File: rtl/lsplit_chk.sv
module lsplit_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          bus_valid,
  input logic          bus_ack,
  input logic [AW-1:0] bus_addr,
  input logic [1:0]    bus_size,
  input logic [DW-1:0] bus_wdata,
  input logic          done,
  input logic          addr_err
);

  // R8
  hold_piece_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ack |=> bus_valid && $stable(bus_addr) && $stable(bus_size) && $stable(bus_wdata));

  // R10
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> !req_ready);

  // R1
  piece_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> ((bus_size == 2'b10) ? !bus_addr[0] :
                   (bus_size == 2'b00) ? (bus_addr[1:0] == 2'b00) : 1'b1));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_valid && req_ready);

  // R9
  err_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> !done && !bus_valid);

endmodule

bind ldst_split lsplit_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .req_ready (req_ready),
  .bus_valid (bus_valid),
  .bus_ack   (bus_ack),
  .bus_addr  (bus_addr),
  .bus_size  (bus_size),
  .bus_wdata (bus_wdata),
  .done      (done),
  .addr_err  (addr_err)
);

// File: tb/sim_ldst_split.sv
`timescale 1ns/1ps
module sim_ldst_split;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write, req_ifetch;
  logic [31:0] req_addr, req_wdata;
  logic [1:0]  req_size;
  logic        done, addr_err;
  logic [31:0] rdata;
  logic        bus_valid, bus_write, bus_ack;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [1:0]  bus_size;

  ldst_split u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .req_ifetch(req_ifetch), .req_wdata(req_wdata), .done(done),
    .addr_err(addr_err), .rdata(rdata), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_write(bus_write),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  always #5 clk = ~clk;

  typedef struct packed {
    logic [31:0] a;
    logic [1:0]  sz;
    logic        wr;
    logic        ifc;
    logic [31:0] wd;
  } req_t;

  typedef struct packed {
    logic [31:0] a;
    logic [1:0]  code;
    logic [31:0] w;
    logic [2:0]  n;
    logic [1:0]  off;
    logic [3:0]  tag;
  } pc_t;

  req_t rq[$];
  pc_t  pq[$];

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // reference model state
  bit          m_busy, m_done, m_err, m_acc, m_wr;
  int          rcnt;
  logic [31:0] m_coll, m_rdata;
  bit          ack_rand;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'b01) ? 1 : (sz == 2'b10) ? 2 : 4;
  endfunction

  // which requirement governs the split of this request
  function automatic int req_tag(input logic [31:0] a, input logic [1:0] sz);
    if (sz == 2'b01) return 1;                     // R1 byte anywhere
    if (sz == 2'b10) return a[0] ? 2 : 1;          // R2 odd word
    case (a[1:0])
      2'd1: return 3;                              // R3 offset 1
      2'd2: return 5;                              // R5 offset 2
      2'd3: return 4;                              // R4 offset 3
      default: return 1;
    endcase
  endfunction

  function automatic void plan(input req_t r);
    int n, c, p, t;
    logic [31:0] a, w;
    logic [1:0] code;
    pc_t pc;
    n = nbytes(r.sz); c = 0; a = r.a; t = req_tag(r.a, r.sz);
    while (n > 0) begin
      if (a[1:0] == 2'b00 && n == 4) begin p = 4; code = 2'b00; end
      else if (!a[0] && n >= 2)       begin p = 2; code = 2'b10; end
      else                             begin p = 1; code = 2'b01; end
      w = '0;
      if (r.wr)
        for (int k = 0; k < p; k++)
          w[31-8*(int'(a[1:0])+k) -: 8] = 8'(r.wd >> (8*(nbytes(r.sz)-1-(c+k))));
      pc.a = a; pc.code = code; pc.w = w; pc.n = 3'(p); pc.off = a[1:0]; pc.tag = 4'(t);
      pq.push_back(pc);
      a = a + 32'(p); c += p; n -= p;
    end
  endfunction

  // model advance on the clock
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_err = 0; m_acc = 0; rcnt = 0;
      m_coll = '0; m_rdata = '0; m_wr = 0;
      pq.delete();
    end else begin
      bit rdy;
      rdy = !m_busy && rcnt >= 2;
      m_done = 0; m_err = 0; m_acc = 0;
      if (m_busy) begin
        if (bus_ack) begin
          pc_t f;
          f = pq.pop_front();
          if (!m_wr)
            for (int k = 0; k < int'(f.n); k++)
              m_coll = (m_coll << 8) | 32'(bus_rdata[31-8*(int'(f.off)+k) -: 8]);
          if (pq.size() == 0) begin
            m_busy = 0; m_done = 1;
            m_rdata = m_wr ? 32'h0 : m_coll;
          end
        end
      end else if (rdy && req_valid) begin
        m_acc = 1;
        if (req_ifetch && req_addr[0]) m_err = 1;
        else begin
          req_t r;
          r.a = req_addr; r.sz = req_size; r.wr = req_write; r.ifc = req_ifetch; r.wd = req_wdata;
          plan(r);
          m_busy = 1; m_coll = '0; m_wr = req_write;
        end
      end
      if (rcnt < 2) rcnt++;
    end
  end

  // compare, then drive, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      string rr;
      rr = (rcnt < 2) ? "R11" : "R10";
      chk(rr, "req_ready", 32'(req_ready), 32'(!m_busy && rcnt >= 2));
      chk((rcnt < 2) ? "R11" : "R8", "bus_valid", 32'(bus_valid), 32'(m_busy));
      chk((rcnt < 2) ? "R11" : "R7", "done", 32'(done), 32'(m_done));
      chk((rcnt < 2) ? "R11" : "R9", "addr_err", 32'(addr_err), 32'(m_err));
      if (m_done) chk("R7", "rdata", rdata, m_rdata);
      if (m_busy && pq.size() > 0 && bus_valid) begin
        string tg;
        tg = $sformatf("R%0d", pq[0].tag);
        chk(tg, "bus_addr", bus_addr, pq[0].a);
        chk(tg, "bus_size", 32'(bus_size), 32'(pq[0].code));
        chk("R6", "bus_write", 32'(bus_write), 32'(m_wr));
        chk("R6", "bus_wdata", bus_wdata, pq[0].w);
      end
      if (m_acc && rq.size() > 0) void'(rq.pop_front());
      m_acc = 0;
      if (rq.size() > 0 && !(ack_rand && ($urandom % 5 == 0))) begin
        req_valid  = 1'b1;
        req_addr   = rq[0].a;
        req_size   = rq[0].sz;
        req_write  = rq[0].wr;
        req_ifetch = rq[0].ifc;
        req_wdata  = rq[0].wd;
      end else begin
        req_valid = 1'b0;
      end
      bus_ack   = ack_rand ? 1'($urandom % 2) : 1'b1;
      bus_rdata = $urandom;
    end
  end

  function automatic req_t mk(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                              input logic ifc, input logic [31:0] wd);
    req_t r;
    r.a = a; r.sz = sz; r.wr = wr; r.ifc = ifc; r.wd = wd;
    return r;
  endfunction

  task automatic drain();
    while (rq.size() > 0 || m_busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0; req_write = 1'b0;
    req_ifetch = 1'b0; req_wdata = '0; bus_ack = 1'b0; bus_rdata = '0; ack_rand = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 aligned, every size
    for (int o = 0; o < 4; o++) rq.push_back(mk(32'h100 + 32'(o), 2'b01, 1'b1, 1'b0, 32'h0000_00A5));
    rq.push_back(mk(32'h202, 2'b10, 1'b0, 1'b0, 32'h0));
    rq.push_back(mk(32'h300, 2'b00, 1'b1, 1'b0, 32'h1122_3344));
    // R2 odd words
    rq.push_back(mk(32'h401, 2'b10, 1'b1, 1'b0, 32'h0000_BEEF));
    rq.push_back(mk(32'h403, 2'b10, 1'b0, 1'b0, 32'h0));
    // R3 R4 R5 misaligned longwords, store and load
    for (int o = 1; o < 4; o++) begin
      rq.push_back(mk(32'h500 + 32'(o), 2'b00, 1'b1, 1'b0, 32'hA1B2_C3D4));
      rq.push_back(mk(32'h5FC + 32'(o), 2'b00, 1'b0, 1'b0, 32'h0));
    end
    // R9 odd fetch, then an even fetch that must split normally
    rq.push_back(mk(32'h701, 2'b10, 1'b0, 1'b1, 32'h0));
    rq.push_back(mk(32'h702, 2'b00, 1'b0, 1'b1, 32'h0));
    drain();
    // R8 random acknowledge gaps, mixed traffic
    ack_rand = 1;
    for (int i = 0; i < 600; i++) begin
      logic [1:0] sz;
      sz = (i % 3 == 0) ? 2'b01 : (i % 3 == 1) ? 2'b10 : 2'b00;
      rq.push_back(mk($urandom, sz, 1'($urandom % 2), ($urandom % 8) == 0, $urandom));
    end
    drain();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    finished = 1;
    failures++;
    $display("FAIL watchdog R8 act=%h exp=%h", 32'(m_busy), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule